// File: doc/BRIEF.md
# Sliding-Window Mean-Square and Frequency Averager

This block sits behind a phase-tracking loop and turns its raw per-sample outputs into slow, well-filtered monitoring values. Every accepted sample carries three phase voltages and one frequency estimate. Each voltage is squared and held in a circular window of the most recent samples. The frequency is held both in a short window and in a long window. Each window keeps a running sum. On every accepted sample the sum gains the new entry and loses the entry being overwritten, so the windowed mean is always current.

The means are published at a decimated rate: once per `DECIM` accepted samples. With a 5 kHz sample strobe and the defaults, the short windows cover 10 ms (50 entries) and the long frequency window covers 200 ms (1000 entries). Each window is divided by its depth through a rounded fixed-point reciprocal. The per-phase RMS value is the integer square root of the published mean square. It is produced by a bit-serial root unit, one result bit per clock.

Samples enter through a valid/ready handshake. The block lowers `in_ready` for the cycle after every publishing sample, and for as long as the root unit is running. An upstream source must hold its sample until it sees `in_ready` high at a clock edge. The result outputs carry no back-pressure: each one is a one-cycle strobe with a value that holds until the next strobe.

Top module: `grid_window_monitor`

## Requirements
- R1: While reset is asserted and right after it, all result strobes are low, all result values are zero and `in_ready` is high.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both high; input presented while `in_ready` is low has no effect. `in_ready` is low in the cycle after each `DECIM`-th accepted sample. When the short windows are full, `in_ready` stays low until `rms_valid` pulses.
- R3: Each voltage is a signed two's-complement sample whose square is stored. When published, `ms_x` equals (S*K + 2^23) >> 24, where S is the sum of the squares of that phase's last 50 accepted samples and K = round(2^24/50).
- R4: `fast_freq` is computed by the same formula over the last 50 accepted unsigned frequency samples.
- R5: `slow_freq` is computed by the same formula over the last 1000 accepted frequency samples, with K = round(2^24/1000).
- R6: `ms_valid`, `fast_valid` and `slow_valid` are one-cycle pulses. They are high in the cycle after the edge that accepted the 50th, 100th, 150th … sample, and their values cover the window ending at that sample.
- R7: `ms_valid` and `fast_valid` stay low until 50 samples have been accepted since reset. `slow_valid` stays low until 1000 have been accepted.
- R8: `rms_x` equals floor(sqrt(`ms_x`)) for each phase. `rms_valid` pulses 16 cycles after `ms_valid`.
- R9: Every result value holds its last published value in all cycles where its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample |
| in_va | input | 16 | Phase A voltage, signed |
| in_vb | input | 16 | Phase B voltage, signed |
| in_vc | input | 16 | Phase C voltage, signed |
| in_freq | input | 16 | Frequency estimate, unsigned |
| ms_valid | output | 1 | Mean-square strobe |
| ms_a | output | 32 | Phase A mean square |
| ms_b | output | 32 | Phase B mean square |
| ms_c | output | 32 | Phase C mean square |
| rms_valid | output | 1 | Root strobe |
| rms_a | output | 16 | Phase A RMS |
| rms_b | output | 16 | Phase B RMS |
| rms_c | output | 16 | Phase C RMS |
| fast_valid | output | 1 | Short-window frequency strobe |
| fast_freq | output | 16 | Short-window mean frequency |
| slow_valid | output | 1 | Long-window frequency strobe |
| slow_freq | output | 16 | Long-window mean frequency |

## Verification
The mean strobes and values are due one cycle after the edge that accepts a publishing sample. The root results are due 17 cycles after that edge, and `in_ready` is low from the accepting edge through the 16 cycles that follow. The reference model notes the edge at which each sample is accepted and schedules each expected strobe at its exact cycle number. It then compares every output, including `in_ready`, at each falling edge against those schedules. While `in_ready` is low the bench drives junk values with `in_valid` high, so any sample taken out of turn would show up in the published means.

// File: rtl/gwm_pkg.sv
`timescale 1ns/1ps
package gwm_pkg;
  localparam int unsigned NUM_PH = 3;

  // rounded fixed-point reciprocal of a window depth
  function automatic longint unsigned recip_const(input int depth, input int shift);
    longint unsigned one;
    longint unsigned d;
    one = 64'd1 << shift;
    d   = longint'(depth);
    return (one + (d >> 1)) / d;
  endfunction
endpackage

// File: rtl/slide_sum.sv
`timescale 1ns/1ps
module slide_sum #(
  parameter int DEPTH = 50,
  parameter int DW    = 32,
  parameter int OUTW  = 32,
  parameter int SHIFT = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   din,
  output logic            filled,
  output logic [OUTW-1:0] mean
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int SUMW = DW + AW;
  localparam int KW   = SHIFT + 1;
  localparam int PW   = SUMW + KW;
  localparam logic [KW-1:0] RECIP = KW'(gwm_pkg::recip_const(DEPTH, SHIFT));
  localparam logic [PW-1:0] HALF  = PW'(1) << (SHIFT - 1);

  logic [DW-1:0]   ring [DEPTH];
  logic [AW-1:0]   wr_ptr;
  logic [CW-1:0]   fill_cnt;
  logic [SUMW-1:0] run_sum;
  logic [DW-1:0]   leaving;
  logic [PW-1:0]   scaled;

  assign filled  = (fill_cnt == CW'(DEPTH));
  assign leaving = filled ? ring[wr_ptr] : '0;

  always_ff @(posedge clk) begin
    if (push) ring[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      fill_cnt <= '0;
      run_sum  <= '0;
    end else if (push) begin
      run_sum <= run_sum + SUMW'(din) - SUMW'(leaving);
      wr_ptr  <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (!filled) fill_cnt <= fill_cnt + CW'(1);
    end
  end

  assign scaled = PW'(run_sum) * PW'(RECIP) + HALF;
  assign mean   = scaled[SHIFT +: OUTW];
endmodule

// File: rtl/iroot_serial.sv
`timescale 1ns/1ps
module iroot_serial #(
  parameter int RAD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RAD_W-1:0]   radicand,
  output logic               busy,
  output logic               done,
  output logic [RAD_W/2-1:0] root
);
  localparam int ROOT_W = RAD_W / 2;
  localparam int CW     = $clog2(ROOT_W + 1);
  localparam int RW     = ROOT_W + 2;

  logic [RAD_W-1:0]  rad_sh;
  logic [RW-1:0]     rem;
  logic [ROOT_W-1:0] q_work;
  logic [CW-1:0]     steps;
  logic [RW+1:0]     rem_try;
  logic [RW+1:0]     trial;
  logic              take;
  logic [RW+1:0]     rem_next;
  logic [ROOT_W-1:0] q_next;

  always_comb begin
    rem_try  = {rem, rad_sh[RAD_W-1 -: 2]};
    trial    = (RW+2)'({q_work, 2'b01});
    take     = (rem_try >= trial);
    rem_next = take ? (rem_try - trial) : rem_try;
    q_next   = {q_work[ROOT_W-2:0], take};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_sh <= '0;
      rem    <= '0;
      q_work <= '0;
      steps  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      root   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rad_sh <= radicand;
        rem    <= '0;
        q_work <= '0;
        steps  <= CW'(ROOT_W);
        busy   <= 1'b1;
      end else if (busy) begin
        rad_sh <= rad_sh << 2;
        rem    <= rem_next[RW-1:0];
        q_work <= q_next;
        steps  <= steps - CW'(1);
        if (steps == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          root <= q_next;
        end
      end
    end
  end
endmodule

// File: rtl/grid_window_monitor.sv
`timescale 1ns/1ps
module grid_window_monitor #(
  parameter int SAMPLE_W    = 16,
  parameter int FREQ_W      = 16,
  parameter int SHORT_DEPTH = 50,
  parameter int LONG_DEPTH  = 1000,
  parameter int DECIM       = 50,
  parameter int RECIP_SHIFT = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_va,
  input  logic [SAMPLE_W-1:0] in_vb,
  input  logic [SAMPLE_W-1:0] in_vc,
  input  logic [FREQ_W-1:0]   in_freq,
  output logic                ms_valid,
  output logic [2*SAMPLE_W-1:0] ms_a,
  output logic [2*SAMPLE_W-1:0] ms_b,
  output logic [2*SAMPLE_W-1:0] ms_c,
  output logic                rms_valid,
  output logic [SAMPLE_W-1:0] rms_a,
  output logic [SAMPLE_W-1:0] rms_b,
  output logic [SAMPLE_W-1:0] rms_c,
  output logic                fast_valid,
  output logic [FREQ_W-1:0]   fast_freq,
  output logic                slow_valid,
  output logic [FREQ_W-1:0]   slow_freq
);
  import gwm_pkg::*;
  localparam int MS_W = 2 * SAMPLE_W;
  localparam int DCW  = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic                             accept;
  logic [DCW-1:0]                   dec_cnt;
  logic                             pub_pend;
  logic [NUM_PH-1:0][SAMPLE_W-1:0]  v_in;
  logic [NUM_PH-1:0][MS_W-1:0]      ms_mean;
  logic [NUM_PH-1:0][MS_W-1:0]      ms_q;
  logic [NUM_PH-1:0][SAMPLE_W-1:0]  root_q;
  logic [NUM_PH-1:0]                ph_filled;
  logic [NUM_PH-1:0]                root_busy;
  logic [NUM_PH-1:0]                root_done;
  logic                             short_full;
  logic                             fshort_full;
  logic                             flong_full;
  logic [FREQ_W-1:0]                fshort_mean;
  logic [FREQ_W-1:0]                flong_mean;
  logic                             root_go;

  assign v_in     = {in_vc, in_vb, in_va};
  assign in_ready = !pub_pend && !(|root_busy);
  assign accept   = in_valid && in_ready;
  assign short_full = ph_filled[0];
  assign root_go  = pub_pend && short_full;

  for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_phase
    logic signed [MS_W-1:0] v_ext;
    logic        [MS_W-1:0] v_sq;
    assign v_ext = MS_W'($signed(v_in[ph]));
    assign v_sq  = $unsigned(v_ext * v_ext);

    slide_sum #(.DEPTH(SHORT_DEPTH), .DW(MS_W), .OUTW(MS_W), .SHIFT(RECIP_SHIFT)) u_win (
      .clk(clk), .rst_n(rst_n), .push(accept), .din(v_sq),
      .filled(ph_filled[ph]), .mean(ms_mean[ph]));

    iroot_serial #(.RAD_W(MS_W)) u_root (
      .clk(clk), .rst_n(rst_n), .start(root_go), .radicand(ms_mean[ph]),
      .busy(root_busy[ph]), .done(root_done[ph]), .root(root_q[ph]));
  end

  slide_sum #(.DEPTH(SHORT_DEPTH), .DW(FREQ_W), .OUTW(FREQ_W), .SHIFT(RECIP_SHIFT)) u_fshort (
    .clk(clk), .rst_n(rst_n), .push(accept), .din(in_freq),
    .filled(fshort_full), .mean(fshort_mean));

  slide_sum #(.DEPTH(LONG_DEPTH), .DW(FREQ_W), .OUTW(FREQ_W), .SHIFT(RECIP_SHIFT)) u_flong (
    .clk(clk), .rst_n(rst_n), .push(accept), .din(in_freq),
    .filled(flong_full), .mean(flong_mean));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_cnt  <= '0;
      pub_pend <= 1'b0;
    end else begin
      pub_pend <= accept && (dec_cnt == DCW'(DECIM - 1));
      if (accept) dec_cnt <= (dec_cnt == DCW'(DECIM - 1)) ? '0 : dec_cnt + DCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_valid   <= 1'b0;
      fast_valid <= 1'b0;
      slow_valid <= 1'b0;
      ms_q       <= '0;
      fast_freq  <= '0;
      slow_freq  <= '0;
    end else begin
      ms_valid   <= 1'b0;
      fast_valid <= 1'b0;
      slow_valid <= 1'b0;
      if (pub_pend && short_full) begin
        ms_valid <= 1'b1;
        ms_q     <= ms_mean;
      end
      if (pub_pend && fshort_full) begin
        fast_valid <= 1'b1;
        fast_freq  <= fshort_mean;
      end
      if (pub_pend && flong_full) begin
        slow_valid <= 1'b1;
        slow_freq  <= flong_mean;
      end
    end
  end

  assign ms_a      = ms_q[0];
  assign ms_b      = ms_q[1];
  assign ms_c      = ms_q[2];
  assign rms_a     = root_q[0];
  assign rms_b     = root_q[1];
  assign rms_c     = root_q[2];
  assign rms_valid = root_done[0];
endmodule

// File: rtl/gwm_checks.sv
`timescale 1ns/1ps
module gwm_checks #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          ms_valid,
  input logic          fast_valid,
  input logic          slow_valid,
  input logic          rms_valid,
  input logic [2*SW-1:0] ms_a,
  input logic [2*SW-1:0] ms_b,
  input logic [SW-1:0] rms_a,
  input logic [SW-1:0] rms_b
);
  localparam int XW = 2 * SW + 2;
  logic [XW-1:0] lo_a, hi_a, lo_b, hi_b;
  assign lo_a = XW'(rms_a) * XW'(rms_a);
  assign hi_a = (XW'(rms_a) + XW'(1)) * (XW'(rms_a) + XW'(1));
  assign lo_b = XW'(rms_b) * XW'(rms_b);
  assign hi_b = (XW'(rms_b) + XW'(1)) * (XW'(rms_b) + XW'(1));

  a_r6_fast_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fast_valid |=> !fast_valid);
  a_r7_slow_needs_fast: assert property (@(posedge clk) disable iff (!rst_n)
    slow_valid |-> fast_valid);
  a_r2_ready_low_on_publish: assert property (@(posedge clk) disable iff (!rst_n)
    ms_valid |-> !in_ready);
  a_r8_root_after_mean: assert property (@(posedge clk) disable iff (!rst_n)
    ms_valid |=> !rms_valid);
  a_r8_root_frees_input: assert property (@(posedge clk) disable iff (!rst_n)
    rms_valid |-> in_ready);
  a_r8_root_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rms_valid |-> (lo_a <= XW'(ms_a)) && (hi_a > XW'(ms_a)) &&
                  (lo_b <= XW'(ms_b)) && (hi_b > XW'(ms_b)));
  a_r9_rms_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rms_valid |-> $stable(rms_a));
  a_r9_ms_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_valid |-> $stable(ms_a));
endmodule

bind grid_window_monitor gwm_checks #(.SW(SAMPLE_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .ms_valid(ms_valid), .fast_valid(fast_valid), .slow_valid(slow_valid),
  .rms_valid(rms_valid), .ms_a(ms_a), .ms_b(ms_b), .rms_a(rms_a), .rms_b(rms_b));

// File: tb/sim_grid_window_monitor.sv
`timescale 1ns/1ps
module sim_grid_window_monitor;
  localparam int TOTAL = 1300;
  localparam int SD = 50;
  localparam int LD = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_va = '0, in_vb = '0, in_vc = '0;
  logic [15:0] in_freq = '0;
  logic ms_valid, rms_valid, fast_valid, slow_valid;
  logic [31:0] ms_a, ms_b, ms_c;
  logic [15:0] rms_a, rms_b, rms_c, fast_freq, slow_freq;

  always #2.5 clk = ~clk;

  grid_window_monitor u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_va(in_va), .in_vb(in_vb), .in_vc(in_vc), .in_freq(in_freq),
    .ms_valid(ms_valid), .ms_a(ms_a), .ms_b(ms_b), .ms_c(ms_c),
    .rms_valid(rms_valid), .rms_a(rms_a), .rms_b(rms_b), .rms_c(rms_c),
    .fast_valid(fast_valid), .fast_freq(fast_freq),
    .slow_valid(slow_valid), .slow_freq(slow_freq));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input longint act, input longint exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle-step)", req, act, exp);
    end
  endtask

  function automatic longint wmean(input longint s, input int depth);
    longint k;
    k = ((64'sd1 <<< 24) + depth / 2) / depth;
    return (s * k + (64'sd1 <<< 23)) >>> 24;
  endfunction

  function automatic longint isqrt(input longint x);
    longint lo, hi, mid;
    lo = 0; hi = 65536;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= x) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic longint qsum(input longint q[$]);
    longint s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction

  // model state
  longint qv0[$], qv1[$], qv2[$], qfs[$], qfl[$];
  longint pend_ms[3], pend_rt[3], exp_ms[3], exp_rt[3];
  longint pend_fast = 0, pend_slow = 0, exp_fast = 0, exp_slow = 0;
  int idx = 0;
  int block_until = 0;
  int ms_due = -1, slow_due = -1, rms_due = -1;

  task automatic drive(input int n);
    int a;
    longint sa, sb, sc, sf;
    if (n % 5 == 0 || idx == TOTAL) begin
      in_valid = 1'b0;
      in_va = 16'sd999; in_vb = -16'sd999; in_vc = 16'sd77; in_freq = 16'd1;
    end else if (n <= block_until) begin
      // not ready: junk that must be ignored (R2)
      in_valid = 1'b1;
      in_va = 16'sh7fff; in_vb = 16'sh7fff; in_vc = 16'sh7fff; in_freq = 16'hffff;
    end else begin
      idx++;
      sa = (idx <= 700) ? ((idx * 37) % 2001) - 1000 : 20000;
      sb = (idx % 50 == 7) ? -32768 : 30000 - (idx % 100) * 300;
      sc = (idx % 2 == 1) ? 32767 : -5;
      sf = (idx <= 600) ? 50000 + (idx % 11) : 47000 + (idx % 5) * 3;
      in_valid = 1'b1;
      in_va = 16'(sa); in_vb = 16'(sb); in_vc = 16'(sc); in_freq = 16'(sf);
      qv0.push_back(sa * sa); qv1.push_back(sb * sb); qv2.push_back(sc * sc);
      qfs.push_back(sf); qfl.push_back(sf);
      if (qv0.size() > SD) begin
        void'(qv0.pop_front()); void'(qv1.pop_front());
        void'(qv2.pop_front()); void'(qfs.pop_front());
      end
      if (qfl.size() > LD) void'(qfl.pop_front());
      a = n + 1;
      if (idx % SD == 0) begin
        if (qv0.size() == SD) begin
          block_until = a + 16;
          ms_due = a + 1;
          rms_due = a + 17;
          pend_ms[0] = wmean(qsum(qv0), SD);
          pend_ms[1] = wmean(qsum(qv1), SD);
          pend_ms[2] = wmean(qsum(qv2), SD);
          for (int p = 0; p < 3; p++) pend_rt[p] = isqrt(pend_ms[p]);
          pend_fast = wmean(qsum(qfs), SD);
        end else begin
          block_until = a;
        end
        if (qfl.size() == LD) begin
          slow_due = a + 1;
          pend_slow = wmean(qsum(qfl), LD);
        end
      end
    end
  endtask

  task automatic check_cycle(input int n);
    string hv;
    if (n == ms_due) begin
      for (int p = 0; p < 3; p++) exp_ms[p] = pend_ms[p];
      exp_fast = pend_fast;
    end
    if (n == slow_due) exp_slow = pend_slow;
    if (n == rms_due) for (int p = 0; p < 3; p++) exp_rt[p] = pend_rt[p];
    chk(longint'(in_ready), longint'(n > block_until), "R2 in_ready");
    chk(longint'(ms_valid), longint'(n == ms_due), "R6 R7 ms_valid");
    chk(longint'(fast_valid), longint'(n == ms_due), "R6 R7 fast_valid");
    chk(longint'(slow_valid), longint'(n == slow_due), "R6 R7 slow_valid");
    chk(longint'(rms_valid), longint'(n == rms_due), "R8 rms_valid");
    hv = (n == ms_due) ? "R3 ms" : "R9 ms hold";
    chk(longint'(ms_a), exp_ms[0], hv);
    chk(longint'(ms_b), exp_ms[1], hv);
    chk(longint'(ms_c), exp_ms[2], hv);
    chk(longint'(fast_freq), exp_fast, (n == ms_due) ? "R4 fast_freq" : "R9 fast hold");
    chk(longint'(slow_freq), exp_slow, (n == slow_due) ? "R5 slow_freq" : "R9 slow hold");
    hv = (n == rms_due) ? "R8 rms" : "R9 rms hold";
    chk(longint'(rms_a), exp_rt[0], hv);
    chk(longint'(rms_b), exp_rt[1], hv);
    chk(longint'(rms_c), exp_rt[2], hv);
  endtask

  initial begin
    int n;
    for (int p = 0; p < 3; p++) begin
      exp_ms[p] = 0; exp_rt[p] = 0; pend_ms[p] = 0; pend_rt[p] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(longint'(in_ready), 1, "R1 in_ready");
    chk(longint'(ms_valid | rms_valid | fast_valid | slow_valid), 0, "R1 strobes");
    chk(longint'(ms_a | ms_b | ms_c), 0, "R1 ms");
    chk(longint'(rms_a | rms_b | rms_c | fast_freq | slow_freq), 0, "R1 results");
    rst_n = 1'b1;
    n = 0;
    drive(n);
    forever begin
      @(negedge clk);
      n++;
      check_cycle(n);
      if (idx == TOTAL && n > block_until + 3) break;
      if (n > 60000) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected below 60000 cycles", n);
        break;
      end
      drive(n);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule